// File: doc/BRIEF.md
# Chunked Partial-Sum Reduction Sequencer

This block folds an integer element stream of arbitrary length into one scalar sum. It does not keep a single running accumulator. It holds a small register of partial sums, one slot per vector position. Incoming elements are dealt into the slots in rotation, so element `i` lands in slot `i mod VL`. When the stream ends, a halving tree runs: on each step the upper half of the active slots is added onto the lower half, and the active length is cut in two. After the last step, slot zero holds the total. The tree uses a configurable number of shared adders, so each halving step takes one or more cycles.

A client raises `req_valid` with the element count while `req_ready` is high. It then streams exactly that many elements over a valid/ready handshake and waits for the one-cycle `done` pulse, when `result` carries the sum. The sum wraps modulo 2^W. A count of zero gives zero. A final chunk that does not fill every slot behaves as if it were padded with zeros. The block takes the next request only after `done`.

Top module: `red_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `elem_ready` is 0 and `done` is 0.
- R2: A request is taken only while `req_ready` is 1. While a reduction is in progress, `req_ready` is 0 and `elem_ready` is never 1 while `req_ready` is 1. A `req_valid` raised during a reduction has no effect on the result.
- R3: After a request with count N, exactly N elements are accepted (`elem_valid` and `elem_ready` both 1 at a rising edge). Gaps in `elem_valid` are tolerated. After the Nth acceptance, `elem_ready` stays 0.
- R4: `result` at `done` equals the sum of the N accepted elements, modulo 2^W.
- R5: A count that is not a multiple of VL gives the same sum as a zero-padded final chunk.
- R6: A count of zero accepts no element and yields `result` = 0.
- R7: The partial-sum slots are cleared when each request is accepted, so a result never includes data from an earlier request.
- R8: `done` is high for exactly one cycle, and `req_ready` is 1 in the cycle after it.
- R9: With F = the sum over h = VL/2, VL/4, …, 1 of ceil(h/NADD), `done` rises F+1 cycles after the edge that accepts the last element. For a zero count, it rises F+2 cycles after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request to start a reduction |
| req_count | input | CNTW | Number of elements in the request |
| req_ready | output | 1 | Block idle, request will be taken |
| elem_valid | input | 1 | Element on `elem_data` is valid |
| elem_data | input | W | Element value |
| elem_ready | output | 1 | Block will accept an element this cycle |
| result | output | W | Reduced sum, valid while `done` is 1 |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench targets the points where a reduction can go wrong without showing an obvious symptom. Short final chunks would expose slots that were not padded or not cleared. All-ones data checks wrap-around, since a design that widened its sum or saturated would return the wrong low bits. A zero count checks the path that a design waiting for a first element would never leave. Offering extra elements after the last one, and raising a second request in the middle of a run, would corrupt the sum in a design that over-counts or restarts. The exact cycle of `done` is checked against the halving schedule, so a tree that skips a level or repeats a lane batch shows up as a latency error.

// File: rtl/red_seq_pkg.sv
// Shared types for the reduction sequencer.
package red_seq_pkg;
    // Sequencer phases: idle, chunked accumulate, halving fold, result pulse.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_FOLD = 2'd2,
        ST_DONE = 2'd3
    } red_state_e;
endpackage

// File: rtl/red_seq_ctrl.sv
// Sequencer control for the reduction: takes a request, counts the elements
// in, steps the halving fold in batches of NADD lanes and raises done.
// Assumes VL is a power of two, VL >= 2, and 1 <= NADD <= VL/2.
module red_seq_ctrl
    import red_seq_pkg::*;
#(
    parameter int VL   = 8,
    parameter int NADD = 2,
    parameter int CNTW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CNTW-1:0]   req_count,
    output logic              req_ready,
    input  logic              elem_valid,
    output logic              elem_ready,
    output logic              done,
    output logic              clr,
    output logic              acc_en,
    output logic [$clog2(VL)-1:0] acc_idx,
    output logic              fold_en,
    output logic [$clog2(VL)-1:0] fold_base,
    output logic [$clog2(VL)-1:0] fold_half
);
    localparam int IW = $clog2(VL);
    localparam logic [IW-1:0] HALF0  = IW'(VL / 2);
    localparam logic [IW:0]   STEP_W = (IW+1)'(NADD);

    red_state_e        state;
    logic [CNTW-1:0]   remaining;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     half;
    logic [IW-1:0]     base;
    logic [IW:0]       base_next;
    logic              level_end;

    // Handshake and datapath strobes decoded from the current phase.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        elem_ready = (state == ST_ACC) && (remaining != '0);
        clr        = req_valid && req_ready;
        acc_en     = elem_valid && elem_ready;
        fold_en    = (state == ST_FOLD) && (half != '0);
        done       = (state == ST_DONE);
        base_next  = {1'b0, base} + STEP_W;
        level_end  = (base_next >= {1'b0, half});
    end

    assign acc_idx   = idx;
    assign fold_base = base;
    assign fold_half = half;

    // Phase register with element counter, slot pointer and fold position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            idx       <= '0;
            half      <= '0;
            base      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (clr) begin
                        remaining <= req_count;
                        idx       <= '0;
                        half      <= HALF0;
                        base      <= '0;
                        state     <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (remaining == '0) begin
                        state <= ST_FOLD;
                    end else if (acc_en) begin
                        remaining <= remaining - 1'b1;
                        idx       <= idx + 1'b1;
                        if (remaining == CNTW'(1)) begin
                            state <= ST_FOLD;
                        end
                    end
                end
                ST_FOLD: begin
                    if (half == '0) begin
                        state <= ST_DONE;
                    end else if (level_end) begin
                        base <= '0;
                        half <= half >> 1;
                        if (half == IW'(1)) begin
                            state <= ST_DONE;
                        end
                    end else begin
                        base <= base_next[IW-1:0];
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/red_seq_bank.sv
// Partial-sum register bank: cleared on request, accumulates one element
// into a chosen slot, or folds up to NADD upper slots onto lower slots per
// cycle through NADD shared adders. Assumes the fold window stays below VL.
module red_seq_bank #(
    parameter int W    = 16,
    parameter int VL   = 8,
    parameter int NADD = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  acc_en,
    input  logic [$clog2(VL)-1:0] acc_idx,
    input  logic [W-1:0]          acc_data,
    input  logic                  fold_en,
    input  logic [$clog2(VL)-1:0] fold_base,
    input  logic [$clog2(VL)-1:0] fold_half,
    output logic [W-1:0]          sum0
);
    localparam int IW = $clog2(VL);

    logic [W-1:0]  part [VL];
    logic [W-1:0]  lane_sum [NADD];
    logic [IW-1:0] lane_idx [NADD];
    logic          lane_act [NADD];
    logic [W-1:0]  acc_sum;

    // One adder per fold lane, each folding slot base+k with slot base+k+half.
    for (genvar k = 0; k < NADD; k++) begin : g_lane
        logic [IW:0] pos;
        always_comb begin
            pos         = {1'b0, fold_base} + (IW+1)'(k);
            lane_idx[k] = pos[IW-1:0];
            lane_act[k] = fold_en && (pos < {1'b0, fold_half});
            lane_sum[k] = part[lane_idx[k]] + part[lane_idx[k] + fold_half];
        end
    end

    // Accumulation adder for the incoming element.
    assign acc_sum = part[acc_idx] + acc_data;

    // Slot update: clear, accumulate or fold, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int e = 0; e < VL; e++) begin
                part[e] <= '0;
            end
        end else if (acc_en) begin
            part[acc_idx] <= acc_sum;
        end else begin
            for (int k = 0; k < NADD; k++) begin
                if (lane_act[k]) begin
                    part[lane_idx[k]] <= lane_sum[k];
                end
            end
        end
    end

    assign sum0 = part[0];
endmodule

// File: rtl/red_seq.sv
// Top of the reduction sequencer: control plus partial-sum bank.
// Assumes VL is a power of two >= 2 and 1 <= NADD <= VL/2.
module red_seq #(
    parameter int W    = 16,
    parameter int VL   = 8,
    parameter int NADD = 2,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [CNTW-1:0] req_count,
    output logic            req_ready,
    input  logic            elem_valid,
    input  logic [W-1:0]    elem_data,
    output logic            elem_ready,
    output logic [W-1:0]    result,
    output logic            done
);
    localparam int IW = $clog2(VL);

    logic          clr, acc_en, fold_en;
    logic [IW-1:0] acc_idx, fold_base, fold_half;

    // Phase sequencing and strobes.
    red_seq_ctrl #(.VL(VL), .NADD(NADD), .CNTW(CNTW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_count(req_count), .req_ready(req_ready),
        .elem_valid(elem_valid), .elem_ready(elem_ready), .done(done),
        .clr(clr), .acc_en(acc_en), .acc_idx(acc_idx),
        .fold_en(fold_en), .fold_base(fold_base), .fold_half(fold_half)
    );

    // Partial-sum storage and adders.
    red_seq_bank #(.W(W), .VL(VL), .NADD(NADD)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr(clr), .acc_en(acc_en), .acc_idx(acc_idx), .acc_data(elem_data),
        .fold_en(fold_en), .fold_base(fold_base), .fold_half(fold_half),
        .sum0(result)
    );
endmodule

// File: rtl/red_seq_chk.sv
// Protocol checker for the reduction sequencer, bound to every instance.
// Tracks the requested count and the accepted elements on its own.
module red_seq_chk #(
    parameter int W    = 16,
    parameter int CNTW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [CNTW-1:0] req_count,
    input logic            req_ready,
    input logic            elem_valid,
    input logic            elem_ready,
    input logic [W-1:0]    result,
    input logic            done
);
    logic [CNTW-1:0] want;
    logic [CNTW-1:0] seen;

    // Latch the requested count and count the accepted elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want <= '0;
            seen <= '0;
        end else if (req_valid && req_ready) begin
            want <= req_count;
            seen <= '0;
        end else if (elem_valid && elem_ready) begin
            seen <= seen + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R8
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);                                         // R8
    AST_NO_ELEM_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !elem_ready);                                  // R2
    AST_ELEM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && elem_ready) |-> (seen < want));               // R3
    AST_ALL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen == want));                                    // R3
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (want == '0)) |-> (result == '0));                  // R6
endmodule

bind red_seq red_seq_chk #(.W(W), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_count(req_count), .req_ready(req_ready),
    .elem_valid(elem_valid), .elem_ready(elem_ready),
    .result(result), .done(done)
);

// File: tb/sim_red_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes each expected sum, the monitor pops
// and compares on done.
module sim_red_seq;
    localparam int W    = 16;
    localparam int VL   = 8;
    localparam int NADD = 2;
    localparam int CNTW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [CNTW-1:0] req_count = '0;
    logic            req_ready;
    logic            elem_valid = 1'b0;
    logic [W-1:0]    elem_data = '0;
    logic            elem_ready;
    logic [W-1:0]    result;
    logic            done;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    always #2 clk = ~clk;

    red_seq #(.W(W), .VL(VL), .NADD(NADD), .CNTW(CNTW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_count(req_count), .req_ready(req_ready),
        .elem_valid(elem_valid), .elem_data(elem_data), .elem_ready(elem_ready),
        .result(result), .done(done)
    );

    // Record one check and report it if it failed.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fold cycles from the halving schedule.
    function automatic int fold_cycles();
        int c = 0;
        for (int h = VL / 2; h >= 1; h = h / 2) c += (h + NADD - 1) / NADD;
        return c;
    endfunction

    // Element generator for the test patterns.
    function automatic logic [W-1:0] gen(input int mode, input int i);
        case (mode)
            0:       return W'(i + 1);
            1:       return '1;
            default: return W'((i * 40503 + 4660) ^ (i << 5));
        endcase
    endfunction

    // Monitor: pop the expected sum on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected done", 1, 0);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(result == e, t, int'(result), int'(e));
            end
        end
    end

    // Driver: one full request with optional gaps and a stray request.
    task automatic run(input int n, input int mode, input bit gaps, input bit intrude,
                       input string tag);
        logic [W-1:0] sum = '0;
        int k;
        for (int i = 0; i < n; i++) sum += gen(mode, i);
        exp_q.push_back(sum);
        tag_q.push_back(tag);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_count = CNTW'(n);
        @(negedge clk);
        req_valid = intrude;
        req_count = CNTW'(n + 3);
        chk(req_ready == 1'b0, "R2 busy after request", int'(req_ready), 0);
        for (int i = 0; i < n; i++) begin
            bit rdy;
            if (gaps && (i % 3 == 1)) begin
                elem_valid = 1'b0;
                @(negedge clk);
            end
            elem_valid = 1'b1;
            elem_data  = gen(mode, i);
            forever begin
                rdy = elem_ready;
                @(negedge clk);
                if (rdy) break;
            end
        end
        // stuff extra data after the last element; it must not be taken
        elem_valid = 1'b1;
        elem_data  = 16'h5A5A;
        chk(elem_ready == 1'b0, "R3 no ready after count", int'(elem_ready), 0);
        k = 1;
        while (!done && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(k == fold_cycles() + ((n == 0) ? 2 : 1), "R9 done latency", k,
            fold_cycles() + ((n == 0) ? 2 : 1));
        elem_valid = 1'b0;
        req_valid  = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R8 single pulse then idle",
            int'({done, req_ready}), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && elem_ready == 1'b0 && done == 1'b0, "R1 reset state",
            int'({req_ready, elem_ready, done}), 4);
        run(8,  0, 1'b0, 1'b0, "R4 full chunk 1..8");
        run(5,  0, 1'b0, 1'b0, "R5 short chunk");
        run(0,  0, 1'b0, 1'b0, "R6 zero count");
        run(20, 1, 1'b1, 1'b0, "R4 wrap all-ones with gaps");
        run(1,  2, 1'b0, 1'b0, "R5 single element");
        run(37, 2, 1'b1, 1'b1, "R2 stray request during run");
        run(3,  0, 1'b0, 1'b0, "R7 cleared after previous run");
        run(16, 2, 1'b0, 1'b0, "R4 two full chunks");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule